// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised bank of external interrupt lines (up to 256) and turns them into per-processor interrupt requests. Each line can be qualified as active-high or active-low, as level-sensitive or edge-latched, and, when edge-latched, as sensitive to both transitions. Software sees every line's enable and pending state, and can enable or disable lines one at a time without a read-modify-write. Software can also set or clear an edge latch directly.

Each source carries a routing word and a processor bitmap. The routing word picks one of the ordinary request pins, and separately the non-maskable request line and an auxiliary request line. The bitmap picks which processors receive that source. A processor's output is asserted while any enabled, pending source is routed to it. Access is through a simple 32-bit word-addressed register bus. A read returns its data on the cycle after the read strobe.

Top module: `shint_ctrl`

## Requirements
- R1: After reset, every enable, polarity, trigger, dual-edge, routing and bitmap bit reads 0, and every request output is low.
- R2: Polarity and level detection use one bit per source, with source n at bit n%32 of the word at byte offset (n/32)*4 in its group. The polarity group is at 0x000. For a level source (trigger bit 0), pending equals the input when polarity is 1 and the inverted input when polarity is 0. Pending reads from the 0x300 group.
- R3: Trigger bit 1 (group 0x080) makes a source edge-latched. It latches on a rising input when polarity is 1 and on a falling input when polarity is 0. The latch then holds after the input returns.
- R4: Dual-edge bit 1 (group 0x100) on an edge source latches on both the rising and the falling transition.
- R5: A write to 0x380 names a source in bits 7:0. Bit 31 set raises that source's edge latch and bit 31 clear lowers it. A number at or above the source count changes nothing.
- R6: Writing 1s to the enable-set group (0x180) enables those sources. Zero bits and bits beyond the source count have no effect. The enable state reads from the 0x280 group.
- R7: Writing 1s to the enable-clear group (0x200) disables those sources, and zero bits have no effect.
- R8: Output irq_out[c*NUM_PIN+p] is high one cycle after a source is pending, enabled, has routing bit 31 set, has pin field value p and has bitmap bit c set. A pin number at or above NUM_PIN drives nothing.
- R9: Routing bit 30 drives nmi_out[c] and bit 29 drives aux_out[c], gated the same way but independent of bit 31 and the pin field.
- R10: Source n's processor bitmap is at byte 0x2000+32*n. Processor v is bit v%32 of word v/32. Bits for processors that do not exist read 0.
- R11: Reads of the write-only addresses (0x180 group, 0x200 group, 0x380), of unused addresses and of words beyond the source count return 0.
- R12: Source n's routing word is at 0x400+4*n. It reads back bits 31, 30, 29 and 5:0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_SRC | Raw external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_out | output | NUM_CPU*NUM_PIN | Ordinary request pins, processor-major |
| nmi_out | output | NUM_CPU | Non-maskable request per processor |
| aux_out | output | NUM_CPU | Auxiliary request per processor |

## Verification
On every cycle, the assertions check several rules. An enable-set write leaves those bits enabled, and an enable-clear write leaves them disabled. An edge latch holds until it is cleared, and a software set or a dual-edge transition raises it. No request pin rises unless some source was both pending and enabled, and a read of an unmapped address returns 0. The bench scenarios cover what the assertions cannot. They check the polarity and edge-direction rules against driven input patterns, the bit and word placement of each group, out-of-range source and pin numbers, and the exact mapping from routing word and bitmap to a given output bit.

// File: rtl/shint_pkg.sv
`timescale 1ns/1ps
package shint_pkg;
  // group index = byte address bits above bit 6, for the first 1 KiB
  localparam int GRP_POL  = 0;
  localparam int GRP_TRIG = 1;
  localparam int GRP_DUAL = 2;
  localparam int GRP_MSET = 3;
  localparam int GRP_MCLR = 4;
  localparam int GRP_MASK = 5;
  localparam int GRP_PEND = 6;
  localparam int GRP_INJ  = 7;
  localparam int NUM_GRP  = 8;

  localparam int ROUTE_BASE = 32'h0400;
  localparam int CPUMAP_BASE = 32'h2000;
  localparam int CPUMAP_STRIDE_W = 8;  // 32 bytes per source

  localparam int PIN_W = 6;

  typedef struct packed {
    logic             en;   // ordinary pin routing
    logic             nmi;  // non-maskable line
    logic             aux;  // auxiliary line
    logic [PIN_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/shint_regs.sv
`timescale 1ns/1ps
module shint_regs
  import shint_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wr_data,
  input  logic [NUM_SRC-1:0] pend,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC-1:0] pol_q,
  output logic [NUM_SRC-1:0] trig_q,
  output logic [NUM_SRC-1:0] dual_q,
  output logic [NUM_SRC-1:0] mask_q,
  output route_t             route_q [NUM_SRC],
  output logic [NUM_CPU-1:0] cpu_q   [NUM_SRC],
  output logic [NUM_SRC-1:0] inj_set,
  output logic [NUM_SRC-1:0] inj_clr
);
  localparam int WA = ADDR_W - 2;
  localparam int GW = ADDR_W - 7;
  localparam int WORDS = (NUM_SRC + 31) / 32;
  localparam int CPU_WORDS = (NUM_CPU + 31) / 32;
  localparam logic [WA-1:0] RT_LO = WA'(ROUTE_BASE >> 2);
  localparam logic [WA-1:0] RT_HI = WA'((ROUTE_BASE >> 2) + NUM_SRC);
  localparam logic [WA-1:0] CM_LO = WA'(CPUMAP_BASE >> 2);
  localparam logic [WA-1:0] CM_HI = WA'((CPUMAP_BASE >> 2) + NUM_SRC * CPUMAP_STRIDE_W);

  // ---------------- address decode ----------------
  logic               aligned;
  logic [WA-1:0]      waddr;
  logic [GW-1:0]      grp;
  logic [4:0]         widx;
  logic [NUM_GRP-1:0] grp_hit;
  logic               rt_hit, cm_hit, rd_hit;
  logic [WA-1:0]      rt_off, cm_off;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    waddr   = addr[ADDR_W-1:2];
    grp     = addr[ADDR_W-1:7];
    widx    = addr[6:2];
    for (int k = 0; k < NUM_GRP; k++) grp_hit[k] = aligned && (grp == GW'(k));
    rt_hit  = aligned && (waddr >= RT_LO) && (waddr < RT_HI);
    cm_hit  = aligned && (waddr >= CM_LO) && (waddr < CM_HI);
    rt_off  = waddr - RT_LO;
    cm_off  = waddr - CM_LO;
    rd_hit  = ((grp_hit[GRP_POL] || grp_hit[GRP_TRIG] || grp_hit[GRP_DUAL] ||
                grp_hit[GRP_MASK] || grp_hit[GRP_PEND]) && (widx < 5'(WORDS))) ||
              rt_hit || (cm_hit && (cm_off[2:0] < 3'(CPU_WORDS)));
  end

  // ---------------- next state ----------------
  logic [NUM_SRC-1:0] pol_n, trig_n, dual_n, mask_n, set_vec, clr_vec;
  route_t             route_n [NUM_SRC];
  logic [NUM_CPU-1:0] cpu_n   [NUM_SRC];
  logic [31:0]        rd_n;

  always_comb begin
    pol_n   = pol_q;
    trig_n  = trig_q;
    dual_n  = dual_q;
    route_n = route_q;
    cpu_n   = cpu_q;
    set_vec = '0;
    clr_vec = '0;
    inj_set = '0;
    inj_clr = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (wr_en && (widx == 5'(i / 32))) begin
        if (grp_hit[GRP_POL])  pol_n[i]  = wr_data[i % 32];
        if (grp_hit[GRP_TRIG]) trig_n[i] = wr_data[i % 32];
        if (grp_hit[GRP_DUAL]) dual_n[i] = wr_data[i % 32];
        if (grp_hit[GRP_MSET] && wr_data[i % 32]) set_vec[i] = 1'b1;
        if (grp_hit[GRP_MCLR] && wr_data[i % 32]) clr_vec[i] = 1'b1;
      end
      if (wr_en && grp_hit[GRP_INJ] && (widx == 5'd0) && (wr_data[7:0] == 8'(i))) begin
        if (wr_data[31]) inj_set[i] = 1'b1;
        else             inj_clr[i] = 1'b1;
      end
      if (wr_en && rt_hit && (rt_off == WA'(i))) begin
        route_n[i].en  = wr_data[31];
        route_n[i].nmi = wr_data[30];
        route_n[i].aux = wr_data[29];
        route_n[i].pin = wr_data[PIN_W-1:0];
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        if (wr_en && cm_hit && (cm_off[WA-1:3] == (WA-3)'(i)) && (cm_off[2:0] == 3'(c / 32)))
          cpu_n[i][c] = wr_data[c % 32];
      end
    end
    mask_n = (mask_q | set_vec) & ~clr_vec;
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (widx == 5'(i / 32)) begin
        if (grp_hit[GRP_POL])  rd_n[i % 32] = pol_q[i];
        if (grp_hit[GRP_TRIG]) rd_n[i % 32] = trig_q[i];
        if (grp_hit[GRP_DUAL]) rd_n[i % 32] = dual_q[i];
        if (grp_hit[GRP_MASK]) rd_n[i % 32] = mask_q[i];
        if (grp_hit[GRP_PEND]) rd_n[i % 32] = pend[i];
      end
      if (rt_hit && (rt_off == WA'(i)))
        rd_n = {route_q[i].en, route_q[i].nmi, route_q[i].aux,
                (29-PIN_W)'(0), route_q[i].pin};
      for (int c = 0; c < NUM_CPU; c++) begin
        if (cm_hit && (cm_off[WA-1:3] == (WA-3)'(i)) && (cm_off[2:0] == 3'(c / 32)))
          rd_n[c % 32] = cpu_q[i][c];
      end
    end
    if (!rd_en) rd_n = '0;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      rd_data <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        route_q[i] <= '0;
        cpu_q[i]   <= '0;
      end
    end else begin
      pol_q   <= pol_n;
      trig_q  <= trig_n;
      dual_q  <= dual_n;
      mask_q  <= mask_n;
      rd_data <= rd_n;
      for (int i = 0; i < NUM_SRC; i++) begin
        route_q[i] <= route_n[i];
        cpu_q[i]   <= cpu_n[i];
      end
    end
  end

  // ---------------- assertions ----------------
  assert_setmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((mask_q & $past(set_vec)) == $past(set_vec)));

  assert_clrmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((mask_q & $past(clr_vec)) == '0));

  assert_rd_unused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rd_data == 32'h0));
endmodule

// File: rtl/shint_detect.sv
`timescale 1ns/1ps
module shint_detect #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] trig,
  input  logic [NUM_SRC-1:0] dual,
  input  logic [NUM_SRC-1:0] inj_set,
  input  logic [NUM_SRC-1:0] inj_clr,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic cur_q, prev_q, latch_q;
    logic act_now, act_prev, evt, latch_n;

    always_comb begin
      act_now  = pol[g] ? cur_q  : ~cur_q;
      act_prev = pol[g] ? prev_q : ~prev_q;
      evt      = trig[g] && (dual[g] ? (cur_q ^ prev_q) : (act_now && !act_prev));
      // a hardware edge or software set wins over a software clear
      latch_n  = (latch_q && !inj_clr[g]) || evt || inj_set[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q   <= 1'b0;
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        cur_q   <= irq_in[g];
        prev_q  <= cur_q;
        latch_q <= latch_n;
      end
    end

    assign pend[g] = trig[g] ? latch_q : act_now;

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !inj_clr[g]) |=> latch_q);

    assert_dual_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[g] && dual[g] && (cur_q != prev_q)) |=> latch_q);

    assert_inject_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inj_set[g] |=> latch_q);
  end
endmodule

// File: rtl/shint_route.sv
`timescale 1ns/1ps
module shint_route
  import shint_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 2,
  parameter int NUM_PIN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC-1:0]         mask,
  input  route_t                     route [NUM_SRC],
  input  logic [NUM_CPU-1:0]         cpu   [NUM_SRC],
  output logic [NUM_CPU*NUM_PIN-1:0] irq_q,
  output logic [NUM_CPU-1:0]         nmi_q,
  output logic [NUM_CPU-1:0]         aux_q
);
  logic [NUM_SRC-1:0]         live;
  logic [NUM_CPU*NUM_PIN-1:0] irq_n;
  logic [NUM_CPU-1:0]         nmi_n, aux_n;

  always_comb begin
    live  = pend & mask;
    irq_n = '0;
    nmi_n = '0;
    aux_n = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (live[i] && cpu[i][c]) begin
          if (route[i].nmi) nmi_n[c] = 1'b1;
          if (route[i].aux) aux_n[c] = 1'b1;
          for (int p = 0; p < NUM_PIN; p++)
            if (route[i].en && (route[i].pin == PIN_W'(p))) irq_n[c*NUM_PIN + p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      nmi_q <= '0;
      aux_q <= '0;
    end else begin
      irq_q <= irq_n;
      nmi_q <= nmi_n;
      aux_q <= aux_n;
    end
  end

  assert_out_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|{irq_q, nmi_q, aux_q}) |-> $past(|live));
endmodule

// File: rtl/shint_ctrl.sv
`timescale 1ns/1ps
module shint_ctrl
  import shint_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 2,
  parameter int NUM_PIN = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wr_data,
  output logic [31:0]                rd_data,
  output logic [NUM_CPU*NUM_PIN-1:0] irq_out,
  output logic [NUM_CPU-1:0]         nmi_out,
  output logic [NUM_CPU-1:0]         aux_out
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NUM_SRC-1:0] pol, trig, dual, mask, pend, inj_set, inj_clr;
  route_t             route [NUM_SRC];
  logic [NUM_CPU-1:0] cpu   [NUM_SRC];

  shint_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pend(pend), .rd_data(rd_data), .pol_q(pol),
    .trig_q(trig), .dual_q(dual), .mask_q(mask), .route_q(route),
    .cpu_q(cpu), .inj_set(inj_set), .inj_clr(inj_clr)
  );

  shint_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol), .trig(trig),
    .dual(dual), .inj_set(inj_set), .inj_clr(inj_clr), .pend(pend)
  );

  shint_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .route(route),
    .cpu(cpu), .irq_q(irq_out), .nmi_q(nmi_out), .aux_q(aux_out)
  );
endmodule

// File: tb/shint_ctrl_test.sv
`timescale 1ns/1ps
module shint_ctrl_test;
  localparam int NSRC = 40;
  localparam int NCPU = 2;
  localparam int NPIN = 4;

  logic            clk = 1'b0;
  logic            arst_n;
  logic [NSRC-1:0] src;
  logic            wr_en, rd_en;
  logic [15:0]     addr;
  logic [31:0]     wr_data, rd_data;
  logic [NCPU*NPIN-1:0] irq_out;
  logic [NCPU-1:0] nmi_out, aux_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shint_ctrl #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .NUM_PIN(NPIN), .ADDR_W(16)) uut (
    .clk(clk), .arst_n(arst_n), .irq_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out),
    .nmi_out(nmi_out), .aux_out(aux_out)
  );

  // {read, requirement, address, write data or expected read data}
  localparam int NV = 28;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 4'd6,  16'h0180, 32'h0000_00F0},  // R6 enable 4..7
    {1'b1, 4'd6,  16'h0280, 32'h0000_00F0},
    {1'b0, 4'd6,  16'h0180, 32'h0000_0000},  // zeros change nothing
    {1'b1, 4'd6,  16'h0280, 32'h0000_00F0},
    {1'b0, 4'd7,  16'h0200, 32'h0000_0030},  // R7 disable 4,5
    {1'b1, 4'd7,  16'h0280, 32'h0000_00C0},
    {1'b0, 4'd6,  16'h0184, 32'hFFFF_FF80},  // only source 39 exists there
    {1'b1, 4'd6,  16'h0284, 32'h0000_0080},
    {1'b1, 4'd11, 16'h0180, 32'h0000_0000},  // R11 write-only reads 0
    {1'b1, 4'd11, 16'h0200, 32'h0000_0000},
    {1'b1, 4'd11, 16'h0380, 32'h0000_0000},
    {1'b1, 4'd11, 16'h07F0, 32'h0000_0000},
    {1'b1, 4'd11, 16'h0040, 32'h0000_0000},
    {1'b0, 4'd12, 16'h040C, 32'hFFFF_FFFF},  // R12 routing word src 3
    {1'b1, 4'd12, 16'h040C, 32'hE000_003F},
    {1'b0, 4'd10, 16'h20A0, 32'hFFFF_FFFF},  // R10 bitmap src 5
    {1'b1, 4'd10, 16'h20A0, 32'h0000_0003},
    {1'b1, 4'd10, 16'h20A4, 32'h0000_0000},
    {1'b0, 4'd2,  16'h0000, 32'h1234_5678},  // R2 polarity readback
    {1'b1, 4'd2,  16'h0000, 32'h1234_5678},
    {1'b0, 4'd2,  16'h0004, 32'hFFFF_FFFF},
    {1'b1, 4'd2,  16'h0004, 32'h0000_00FF},
    {1'b0, 4'd2,  16'h0000, 32'h0000_0000},
    {1'b0, 4'd2,  16'h0004, 32'h0000_0000},
    {1'b0, 4'd7,  16'h0200, 32'hFFFF_FFFF},
    {1'b0, 4'd7,  16'h0204, 32'hFFFF_FFFF},
    {1'b1, 4'd7,  16'h0280, 32'h0000_0000},
    {1'b1, 4'd7,  16'h0284, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rdchk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic outchk(input string tag, input logic [7:0] e_irq,
                        input logic [1:0] e_nmi, input logic [1:0] e_aux);
    settle();
    chk({tag, " irq"}, 32'(irq_out), 32'(e_irq));
    chk({tag, " nmi"}, 32'(nmi_out), 32'(e_nmi));
    chk({tag, " aux"}, 32'(aux_out), 32'(e_aux));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; src = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 nmi/aux", 32'({nmi_out, aux_out}), 32'h0);
    rdchk("R1 enable", 16'h0280, 32'h0);
    rdchk("R1 polarity", 16'h0000, 32'h0);
    rdchk("R1 trigger", 16'h0080, 32'h0);
    rdchk("R1 dual", 16'h0100, 32'h0);
    rdchk("R1 route", 16'h0404, 32'h0);
    // R2 active-low level with inputs low: all pending
    rdchk("R2 pend w0 reset", 16'h0300, 32'hFFFF_FFFF);
    rdchk("R2 pend w1 reset", 16'h0304, 32'h0000_00FF);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][52]) begin
        logic [31:0] d;
        rd(VEC[v][47:32], d);
        n_chk++;
        if (d !== VEC[v][31:0]) begin
          n_bad++;
          $display("FAIL R%0d vector %0d: got %h expected %h", VEC[v][51:48], v, d, VEC[v][31:0]);
        end
      end else begin
        wr(VEC[v][47:32], VEC[v][31:0]);
      end
    end

    // R2 level polarity
    src = 40'hA5; settle();
    rdchk("R2 level active-low", 16'h0300, 32'hFFFF_FF5A);
    wr(16'h0000, 32'hFFFF_FFFF); settle();
    rdchk("R2 level active-high", 16'h0300, 32'h0000_00A5);

    // R3 rising edge on source 2
    src = '0; wr(16'h0080, 32'h4); settle();
    rdchk("R3 idle", 16'h0300, 32'h0);
    src = 40'h4; settle();
    rdchk("R3 rise latched", 16'h0300, 32'h4);
    src = '0; settle();
    rdchk("R3 latch holds", 16'h0300, 32'h4);
    wr(16'h0380, 32'h0000_0002); settle();
    rdchk("R5 clear latch", 16'h0300, 32'h0);
    // R3 falling edge on source 3 (polarity 0)
    wr(16'h0000, 32'hFFFF_FFF7); wr(16'h0080, 32'hC); settle();
    rdchk("R3 fall idle", 16'h0300, 32'h0);
    src = 40'h8; settle();
    rdchk("R3 rise ignored at pol 0", 16'h0300, 32'h0);
    src = '0; settle();
    rdchk("R3 fall latched", 16'h0300, 32'h8);
    wr(16'h0380, 32'h0000_0003); settle();
    rdchk("R3 fall cleared", 16'h0300, 32'h0);

    // R4 dual edge on source 4
    wr(16'h0000, 32'hFFFF_FFFF); wr(16'h0080, 32'h1C); wr(16'h0100, 32'h10); settle();
    rdchk("R4 idle", 16'h0300, 32'h0);
    src = 40'h10; settle();
    rdchk("R4 rise", 16'h0300, 32'h10);
    wr(16'h0380, 32'h0000_0004); settle();
    rdchk("R4 cleared", 16'h0300, 32'h0);
    src = '0; settle();
    rdchk("R4 fall", 16'h0300, 32'h10);
    wr(16'h0380, 32'h0000_0004); settle();

    // R5 software injection on source 39
    wr(16'h0084, 32'h80); settle();
    rdchk("R5 idle", 16'h0304, 32'h7F);
    wr(16'h0380, 32'h8000_0027); settle();
    rdchk("R5 set", 16'h0304, 32'hFF);
    wr(16'h0380, 32'h0000_0027); settle();
    rdchk("R5 clear", 16'h0304, 32'h7F);
    wr(16'h0380, 32'h8000_0028); settle();
    rdchk("R5 out of range w1", 16'h0304, 32'h7F);
    rdchk("R5 out of range w0", 16'h0300, 32'h0);

    // R8 routing source 1 to cpu 1 pin 2
    src = 40'h2;
    wr(16'h0180, 32'h2); wr(16'h0404, 32'h8000_0002); wr(16'h2020, 32'h2);
    outchk("R8 routed", 8'h40, 2'b00, 2'b00);
    src = '0;
    outchk("R8 not pending", 8'h00, 2'b00, 2'b00);
    src = 40'h2;
    outchk("R8 pending again", 8'h40, 2'b00, 2'b00);
    wr(16'h0200, 32'h2);
    outchk("R7 disabled", 8'h00, 2'b00, 2'b00);
    wr(16'h0180, 32'h2); wr(16'h0404, 32'h8000_0005);
    outchk("R8 pin out of range", 8'h00, 2'b00, 2'b00);
    // R9 nmi and aux lines
    wr(16'h0404, 32'h6000_0000);
    outchk("R9 nmi+aux", 8'h00, 2'b10, 2'b10);
    wr(16'h0404, 32'h4000_0001); wr(16'h2020, 32'h3);
    outchk("R9 nmi both cpus", 8'h00, 2'b11, 2'b00);
    // R10 bitmap to both processors
    wr(16'h0404, 32'h8000_0001);
    outchk("R10 both cpus pin 1", 8'h22, 2'b00, 2'b00);
    rdchk("R10 bitmap readback", 16'h2020, 32'h3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule